// File: doc/BRIEF.md
# Memory Range Scanner for a CRC Engine

This block walks a region of memory one word at a time and hands every word to the data buffer of a CRC engine. Software writes a start address and an end address, enables the scanner and sets its go bit. The scanner then waits until the CRC engine runs and its buffer has room. It issues a synchronous read and passes the returned word to the CRC buffer, with both bytes written in the same cycle. It moves on to the next address and repeats until it has transferred the word at the end address.

The scan also ends early if the memory reports that an address is not implemented. In that case the word is not transferred. Software may abort a scan at any time by clearing go. Whenever go falls while the block is enabled, a sticky interrupt flag is raised. Software clears the flag, and a separate enable gates it onto the interrupt line. Dropping the enable bit returns the controller to idle but keeps both address registers. The start register always shows the next address to be scanned.

Only continuous back-to-back scanning is modelled. The mode field must select that mode, or a start request is refused.

Top module: `scan_crc_feeder`

## Requirements
- R1: After reset, scan_go, mem_re, crc_wr, scan_flag and irq are 0, and scan_addr is 0.
- R2: A go_set pulse starts a scan (scan_go is 1 from the next cycle) only when cfg_en is 1 and cfg_mode is 2'b00 (continuous). Any other cfg_mode value, or cfg_en at 0, leaves scan_go at 0.
- R3: mem_re is asserted in a cycle only if the cycle before had crc_go at 1 and crc_full at 0. After a crc_wr, crc_full is not examined before the second cycle that follows it.
- R4: Words reach the CRC buffer in ascending address order. crc_hi carries mem_rdata[15:8] and crc_lo carries mem_rdata[7:0]. crc_wr is a one-cycle pulse per word. mem_rdata and mem_valid are taken in the cycle after mem_re.
- R5: After each transferred word other than the last, scan_addr increments by one. The scan ends after the word at the end address is transferred: scan_go falls in the same cycle that crc_wr rises, and scan_addr is left equal to the end address.
- R6: If mem_valid is 0 for a read, that word is not transferred, scan_go clears, and scan_addr stays at the unimplemented address.
- R7: A go_clr pulse during a scan clears scan_go in the next cycle. No further mem_re or crc_wr follows.
- R8: scan_flag is set one cycle after scan_go falls while cfg_en is 1, and it stays set until a flag_clr pulse. irq equals scan_flag AND irq_en.
- R9: Driving cfg_en to 0 stops a scan and clears scan_go without setting scan_flag. scan_addr keeps its value.
- R10: Writes to the start or end address (lo_wr, hi_wr) while scan_go is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Scanner enable |
| cfg_mode | input | 2 | Scan mode select; 2'b00 is continuous |
| go_set | input | 1 | Pulse: request a scan start |
| go_clr | input | 1 | Pulse: abort the scan in progress |
| lo_wr | input | 1 | Write addr_wdata into the start address |
| hi_wr | input | 1 | Write addr_wdata into the end address |
| addr_wdata | input | AW | Address write data |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Pulse: clear the interrupt flag |
| crc_go | input | 1 | CRC engine is running |
| crc_full | input | 1 | CRC data buffer is occupied |
| mem_rdata | input | DW | Read data, the cycle after mem_re |
| mem_valid | input | 1 | Address was implemented, the cycle after mem_re |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| crc_wr | output | 1 | Write strobe into the CRC buffer |
| crc_hi | output | DW-8 | Upper part of the word for the CRC |
| crc_lo | output | 8 | Low byte of the word for the CRC |
| scan_go | output | 1 | Scan in progress |
| scan_addr | output | AW | Next address to be scanned |
| scan_flag | output | 1 | Sticky end-of-scan flag |
| irq | output | 1 | Gated interrupt |

## Verification
The bench sweeps start addresses, range lengths and CRC buffer-busy latencies, including single-word ranges. A design that re-polled the buffer too early would issue a read while crc_full is high and overwrite a pending word. An off-by-one end test would drop or add the last word and leave scan_addr past the end address. Ranges that run into unimplemented addresses catch a design that transfers the invalid word or keeps scanning. Aborts, disables and address writes in mid-scan expose a design that emits a stray write, raises the flag on disable, or lets software move the pointer during a scan.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_RD,
    S_RESP,
    S_HOLD
  } scan_state_t;

  localparam logic [1:0] MODE_CONT = 2'b00;
endpackage

// File: rtl/scan_addr_regs.sv
module scan_addr_regs #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic [AW-1:0] wdata,
  input  logic          adv,
  output logic [AW-1:0] lo_q,
  output logic          last
);
  logic [AW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (adv)
        lo_q <= lo_q + AW'(1);
      else if (lo_wr && !busy)
        lo_q <= wdata;
      if (hi_wr && !busy)
        hi_q <= wdata;
    end
  end

  assign last = (lo_q == hi_q);

  // pointer only moves by the FSM advance while scanning
  assert_ptr_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !adv) |=> $stable(lo_q));
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [1:0]    mode,
  input  logic          go_set,
  input  logic          go_clr,
  input  logic          crc_go,
  input  logic          crc_full,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_valid,
  input  logic          last,
  output logic          scan_go,
  output logic          mem_re,
  output logic          crc_wr,
  output logic [DW-9:0] crc_hi,
  output logic [7:0]    crc_lo,
  output logic          adv
);
  scan_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      scan_go <= 1'b0;
      mem_re  <= 1'b0;
      crc_wr  <= 1'b0;
      crc_hi  <= '0;
      crc_lo  <= '0;
    end else begin
      mem_re <= 1'b0;
      crc_wr <= 1'b0;
      if (!en) begin
        state   <= S_IDLE;
        scan_go <= 1'b0;
      end else if (scan_go && go_clr) begin
        state   <= S_IDLE;
        scan_go <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: if (go_set && mode == MODE_CONT) begin
            scan_go <= 1'b1;
            state   <= S_REQ;
          end
          S_REQ: if (crc_go && !crc_full) begin
            mem_re <= 1'b1;
            state  <= S_RD;
          end
          S_RD: state <= S_RESP;
          S_RESP: begin
            if (mem_valid) begin
              crc_wr <= 1'b1;
              crc_hi <= mem_rdata[DW-1:8];
              crc_lo <= mem_rdata[7:0];
            end
            if (mem_valid && !last) begin
              state <= S_HOLD;
            end else begin
              state   <= S_IDLE;
              scan_go <= 1'b0;
            end
          end
          S_HOLD: state <= S_REQ;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign adv = en && !go_clr && (state == S_RESP) && mem_valid && !last;

  assert_read_when_ready_R3: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> $past(crc_go && !crc_full));
  assert_wr_single_R4: assert property (@(posedge clk) disable iff (rst)
    crc_wr |=> !crc_wr);
  assert_start_legal_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(scan_go) |-> $past(go_set && en && mode == MODE_CONT));
endmodule

// File: rtl/scan_flag_irq.sv
module scan_flag_irq (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scan_go,
  input  logic flag_clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic go_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      go_d <= 1'b0;
      flag <= 1'b0;
    end else begin
      go_d <= scan_go;
      if (go_d && !scan_go && en)
        flag <= 1'b1;
      else if (flag_clr)
        flag <= 1'b0;
    end
  end

  assign irq = flag && irq_en;

  assert_flag_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(scan_go) && en) |=> flag);
endmodule

// File: rtl/scan_crc_feeder.sv
module scan_crc_feeder #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_mode,
  input  logic          go_set,
  input  logic          go_clr,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic [AW-1:0] addr_wdata,
  input  logic          irq_en,
  input  logic          flag_clr,
  input  logic          crc_go,
  input  logic          crc_full,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_valid,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic          crc_wr,
  output logic [DW-9:0] crc_hi,
  output logic [7:0]    crc_lo,
  output logic          scan_go,
  output logic [AW-1:0] scan_addr,
  output logic          scan_flag,
  output logic          irq
);
  logic adv;
  logic last;

  scan_addr_regs #(.AW(AW)) u_addr (
    .clk   (clk),
    .rst   (rst),
    .busy  (scan_go),
    .lo_wr (lo_wr),
    .hi_wr (hi_wr),
    .wdata (addr_wdata),
    .adv   (adv),
    .lo_q  (scan_addr),
    .last  (last)
  );

  scan_fsm #(.DW(DW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_en),
    .mode      (cfg_mode),
    .go_set    (go_set),
    .go_clr    (go_clr),
    .crc_go    (crc_go),
    .crc_full  (crc_full),
    .mem_rdata (mem_rdata),
    .mem_valid (mem_valid),
    .last      (last),
    .scan_go   (scan_go),
    .mem_re    (mem_re),
    .crc_wr    (crc_wr),
    .crc_hi    (crc_hi),
    .crc_lo    (crc_lo),
    .adv       (adv)
  );

  scan_flag_irq u_flag (
    .clk      (clk),
    .rst      (rst),
    .en       (cfg_en),
    .scan_go  (scan_go),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .flag     (scan_flag),
    .irq      (irq)
  );

  assign mem_addr = scan_addr;
endmodule

// File: tb/scan_crc_feeder_tb.sv
`timescale 1ns/1ps
module scan_crc_feeder_tb;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b1;
  logic [1:0] cfg_mode = 2'b00;
  logic go_set = 0, go_clr = 0, lo_wr = 0, hi_wr = 0;
  logic [AW-1:0] addr_wdata = '0;
  logic irq_en = 0, flag_clr = 0, crc_go = 1;
  logic crc_full;
  logic [DW-1:0] mem_rdata;
  logic mem_valid;
  logic mem_re, crc_wr, scan_go, scan_flag, irq;
  logic [AW-1:0] mem_addr, scan_addr;
  logic [DW-9:0] crc_hi;
  logic [7:0] crc_lo;

  int checks = 0, errors = 0;
  int limit = 256, lat = 0, fcnt = 0;
  int exp_addr = 0, word_cnt = 0, data_err = 0, blk_err = 0, re_cnt = 0;
  logic prev_full = 1'b0, prev_go = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  scan_crc_feeder #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .go_set(go_set), .go_clr(go_clr), .lo_wr(lo_wr), .hi_wr(hi_wr),
    .addr_wdata(addr_wdata), .irq_en(irq_en), .flag_clr(flag_clr),
    .crc_go(crc_go), .crc_full(crc_full), .mem_rdata(mem_rdata),
    .mem_valid(mem_valid), .mem_re(mem_re), .mem_addr(mem_addr),
    .crc_wr(crc_wr), .crc_hi(crc_hi), .crc_lo(crc_lo), .scan_go(scan_go),
    .scan_addr(scan_addr), .scan_flag(scan_flag), .irq(irq)
  );

  function automatic logic [15:0] word_of(input int a);
    logic [7:0] b;
    b = a[7:0];
    return {b ^ 8'hA5, ~b};
  endfunction

  // memory model: synchronous read, validity below limit
  always @(posedge clk) begin
    mem_rdata <= word_of(int'(mem_addr));
    mem_valid <= (int'(mem_addr) < limit);
  end

  // CRC buffer model: busy for lat cycles after each write
  always @(posedge clk) begin
    if (rst) begin
      crc_full <= 1'b0; fcnt <= 0;
    end else if (crc_wr && lat > 0) begin
      crc_full <= 1'b1; fcnt <= lat;
    end else if (fcnt > 1) begin
      fcnt <= fcnt - 1;
    end else begin
      fcnt <= 0; crc_full <= 1'b0;
    end
  end

  // scoreboard, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (crc_wr) begin
        if ({crc_hi, crc_lo} != word_of(exp_addr)) data_err++;
        exp_addr++;
        word_cnt++;
      end
      if (mem_re) begin
        re_cnt++;
        if (prev_full || !prev_go) blk_err++;
      end
    end
    prev_full = crc_full;
    prev_go = crc_go;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_range(input int lo, input int hi);
    @(negedge clk); lo_wr = 1; addr_wdata = lo[AW-1:0];
    @(negedge clk); lo_wr = 0; hi_wr = 1; addr_wdata = hi[AW-1:0];
    @(negedge clk); hi_wr = 0;
  endtask

  task automatic pulse_go();
    @(negedge clk); go_set = 1;
    @(negedge clk); go_set = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && scan_go; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_scan(input int lo, input int hi, input int l, input int lim);
    int exp_n, exp_end;
    lat = l; limit = lim;
    write_range(lo, hi);
    exp_addr = lo; word_cnt = 0; data_err = 0; blk_err = 0;
    pulse_go();
    wait_idle();
    if (lo >= lim) begin exp_n = 0; exp_end = lo; end
    else if (hi < lim) begin exp_n = hi - lo + 1; exp_end = hi; end
    else begin exp_n = lim - lo; exp_end = lim; end
    chk("R4 word count", word_cnt, exp_n);
    chk("R4 word data/order", data_err, 0);
    chk("R3 read while blocked", blk_err, 0);
    chk((hi < lim) ? "R5 final addr" : "R6 stop addr", int'(scan_addr), exp_end);
    chk("R8 flag after end", int'(scan_flag), 1);
    clear_flag();
  endtask

  initial begin
    int snap, snap_re;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 scan_go", int'(scan_go), 0);
    chk("R1 mem_re", int'(mem_re), 0);
    chk("R1 crc_wr", int'(crc_wr), 0);
    chk("R1 flag", int'(scan_flag), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 scan_addr", int'(scan_addr), 0);

    // R2: refused starts
    cfg_en = 0; pulse_go(); @(negedge clk);
    chk("R2 start while disabled", int'(scan_go), 0);
    cfg_en = 1;
    for (int m = 1; m < 4; m++) begin
      cfg_mode = m[1:0]; pulse_go(); @(negedge clk);
      chk("R2 start in other mode", int'(scan_go), 0);
    end
    cfg_mode = 2'b00;

    // R3 / R10: stalled by crc_go, address writes ignored mid-scan
    crc_go = 0; lat = 0; limit = 256;
    write_range(5, 9);
    exp_addr = 5; word_cnt = 0; data_err = 0; re_cnt = 0;
    pulse_go();
    chk("R2 start accepted", int'(scan_go), 1);
    repeat (6) @(negedge clk);
    chk("R3 no read while crc idle", re_cnt, 0);
    write_range(40, 44);
    chk("R10 start addr write ignored", int'(scan_addr), 5);
    crc_go = 1;
    wait_idle();
    chk("R10 end addr write ignored", word_cnt, 5);
    chk("R10 final addr", int'(scan_addr), 9);
    chk("R4 data after stall", data_err, 0);

    // R8: interrupt gating and clearing
    chk("R8 flag set", int'(scan_flag), 1);
    chk("R8 irq gated off", int'(irq), 0);
    @(negedge clk); irq_en = 1; @(negedge clk);
    chk("R8 irq enabled", int'(irq), 1);
    clear_flag();
    chk("R8 flag cleared", int'(scan_flag), 0);
    chk("R8 irq cleared", int'(irq), 0);
    irq_en = 0;

    // R7: abort
    lat = 3; write_range(10, 60);
    exp_addr = 10; word_cnt = 0; pulse_go();
    repeat (30) @(negedge clk);
    go_clr = 1; @(negedge clk); go_clr = 0;
    chk("R7 go cleared", int'(scan_go), 0);
    snap = word_cnt; snap_re = re_cnt;
    repeat (12) @(negedge clk);
    chk("R7 no write after abort", word_cnt, snap);
    chk("R7 no read after abort", re_cnt, snap_re);
    chk("R8 flag after abort", int'(scan_flag), 1);
    clear_flag();

    // R9: disable mid-scan
    lat = 2; write_range(20, 80); exp_addr = 20; pulse_go();
    repeat (25) @(negedge clk);
    cfg_en = 0; snap = int'(scan_addr);
    @(negedge clk);
    chk("R9 go cleared", int'(scan_go), 0);
    repeat (4) @(negedge clk);
    chk("R9 no flag", int'(scan_flag), 0);
    chk("R9 addr kept", int'(scan_addr), snap);
    cfg_en = 1; @(negedge clk);

    // R6: unimplemented addresses
    do_scan(197, 204, 1, 200);
    do_scan(200, 203, 0, 200);
    do_scan(252, 255, 2, 256);

    // sweep of start, length and buffer latency
    for (int lo = 0; lo < 12; lo++)
      for (int sp = 0; sp < 6; sp++)
        for (int l = 0; l < 4; l++)
          do_scan(lo * 7, lo * 7 + sp, l, 256);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule